// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Memory Word Guard

This block protects a 16-bit memory word with 6 check bits. When the word is written, it computes the check bits from the data so that both can be stored together. When the word is read, it takes the stored data and check bits and computes the check bits again from the data. It compares the two sets into a syndrome, classifies the error, and drives two active-low flags: one for an error it can correct and one for an error it cannot correct.

Each data bit has a distinct weight-3 column in the code, and each check bit has its own one-hot column. Because of this, any single error can be located, and any double error gives an even syndrome that is caught. A fix-enable input chooses what happens on a single data-bit error. When it is high, the faulty bit is inverted on the output word. When it is low, the word passes through unchanged and only the flags report the error. Detect-only operation is the safe choice when errors spanning three or more bits are possible. Such errors can alias onto a valid single-bit column, and correcting them would corrupt a further bit.

The write encoder is purely combinational. The read result (word, syndrome and flags) goes through one output register when `OUT_REG` is 1, which is the default, or is combinational when it is 0.

Top module: `edac16_secded`

## Requirements
- R1: `wr_check[j]` is the XOR of every `wr_data[i]` whose column has bit j set. The columns for data bits 15 down to 0 are, in hex: 34, 2A, 29, 25, 32, 1A, 16, 13, 31, 23, 15, 0B, 2C, 1C, 0E, 0D.
- R2: `syndrome[5:0]` equals the check bits recomputed from `rd_data` XOR `rd_check`, and `syndrome[7:6]` is always 0. The column of check bit j is the one-hot value 1<<j.
- R3: A zero syndrome leaves both `ce_n` and `nce_n` high, and `out_data` equals `rd_data`.
- R4: A syndrome equal to the column of data bit i drives `ce_n` low and leaves `nce_n` high. When `fix_en` is 1, `out_data` is `rd_data` with bit i inverted.
- R5: When `fix_en` is 0, `out_data` always equals `rd_data`. The flags still follow R3 to R8.
- R6: A syndrome with exactly one bit set drives `ce_n` low and leaves `nce_n` high. `out_data` equals `rd_data`, and no corrected check bits are output.
- R7: A nonzero syndrome with an even number of set bits drives `nce_n` low and leaves `ce_n` high, and `out_data` equals `rd_data`. All double errors fall in this class, for example an error on data bit 4 and check bit 2, which gives 0F.
- R8: A syndrome with an odd number of set bits that is neither one-hot nor a data column drives `nce_n` low and leaves `ce_n` high, and `out_data` equals `rd_data`.
- R9: With `OUT_REG`=1, `out_data`, `syndrome`, `ce_n` and `nce_n` reflect the read inputs of the previous rising edge. While `rst_n` is low they are 0, 0, 1 and 1.
- R10: A triple error whose syndrome aliases a data column is treated as in R4. For example, errors on data bits 0 and 14 and check bit 1 give 25, and in fix mode data bit 12 is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the read-result register |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 16 | Data word being written |
| wr_check | output | 6 | Check bits to store with `wr_data` |
| rd_data | input | 16 | Data word read from memory |
| rd_check | input | 6 | Check bits read from memory |
| fix_en | input | 1 | 1 = invert a located data bit, 0 = detect only |
| out_data | output | 16 | Delivered read word |
| syndrome | output | 8 | Error syndrome, upper two bits zero |
| ce_n | output | 1 | Low when a correctable error is seen |
| nce_n | output | 1 | Low when an uncorrectable error is seen |

## Verification
The write encoder and the read classifier work in the same cycle on unrelated words. The bench therefore drives a fresh random `wr_data` alongside every read case and judges `wr_check` at the same sampling point as the registered read result. A fault in either path then cannot hide behind the other. Read cases cover every single flip in both fix modes, every double flip, the aliasing triple, a 4-bit group failure, and random injections of zero to three flips. Each is compared with a model built from the column table alone.

// File: rtl/edac16_pkg.sv
package edac16_pkg;

    localparam int DW = 16;
    localparam int CW = 6;
    localparam int SW = 8;

    // Syndrome column of each data bit, index 0 first.
    localparam logic [CW-1:0] COLS [DW] = '{
        6'h0D, 6'h0E, 6'h1C, 6'h2C, 6'h0B, 6'h15, 6'h23, 6'h31,
        6'h13, 6'h16, 6'h1A, 6'h32, 6'h25, 6'h29, 6'h2A, 6'h34
    };

    typedef struct packed {
        logic [DW-1:0] data;
        logic [SW-1:0] syn;
        logic          ce_n;
        logic          nce_n;
    } edac_out_t;

    localparam edac_out_t OUT_RST = '{data: '0, syn: '0, ce_n: 1'b1, nce_n: 1'b1};

    // Data bits that feed check bit j.
    function automatic logic [DW-1:0] row_mask(input int j);
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < DW; i++) begin
            m[i] = COLS[i][j];
        end
        return m;
    endfunction

endpackage

// File: rtl/edac16_parity.sv
module edac16_parity
    import edac16_pkg::*;
(
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] chk_o
);

    for (genvar j = 0; j < CW; j++) begin : g_row
        localparam logic [DW-1:0] MASK = row_mask(j);
        assign chk_o[j] = ^(data_i & MASK);
    end

endmodule

// File: rtl/edac16_classify.sv
module edac16_classify
    import edac16_pkg::*;
(
    input  logic [CW-1:0] syn_i,
    output logic [DW-1:0] hit_o,
    output logic          chk_err_o,
    output logic          multi_o
);

    for (genvar i = 0; i < DW; i++) begin : g_col
        assign hit_o[i] = (syn_i == COLS[i]);
    end

    always_comb begin
        chk_err_o = ($countones(syn_i) == 1);
        multi_o   = (|syn_i) && !chk_err_o && !(|hit_o);
    end

endmodule

// File: rtl/edac16_secded.sv
module edac16_secded
    import edac16_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] wr_data,
    output logic [CW-1:0] wr_check,
    input  logic [DW-1:0] rd_data,
    input  logic [CW-1:0] rd_check,
    input  logic          fix_en,
    output logic [DW-1:0] out_data,
    output logic [SW-1:0] syndrome,
    output logic          ce_n,
    output logic          nce_n
);

    localparam int PAD = SW - CW;

    logic [CW-1:0] rd_recalc;
    logic [CW-1:0] syn;
    logic [DW-1:0] hit;
    logic          chk_err;
    logic          multi;
    edac_out_t     state_d;
    edac_out_t     state_q;

    edac16_parity u_wr_par (
        .data_i (wr_data),
        .chk_o  (wr_check)
    );

    edac16_parity u_rd_par (
        .data_i (rd_data),
        .chk_o  (rd_recalc)
    );

    assign syn = rd_recalc ^ rd_check;

    edac16_classify u_cls (
        .syn_i     (syn),
        .hit_o     (hit),
        .chk_err_o (chk_err),
        .multi_o   (multi)
    );

    always_comb begin
        state_d       = OUT_RST;
        state_d.data  = rd_data ^ (fix_en ? hit : '0);
        state_d.syn   = {{PAD{1'b0}}, syn};
        state_d.ce_n  = !((|hit) || chk_err);
        state_d.nce_n = !multi;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                state_q <= OUT_RST;
            end else begin
                state_q <= state_d;
            end
        end
    end else begin : g_comb
        assign state_q = state_d;
    end

    assign out_data = state_q.data;
    assign syndrome = state_q.syn;
    assign ce_n     = state_q.ce_n;
    assign nce_n    = state_q.nce_n;

endmodule

// File: rtl/edac16_secded_chk.sv
module edac16_secded_chk
    import edac16_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] rd_data,
    input logic          fix_en,
    input logic [DW-1:0] out_data,
    input logic [SW-1:0] syndrome,
    input logic          ce_n,
    input logic          nce_n
);

    logic [DW-1:0] rd_p;
    logic          fix_p;
    logic          vld;

    if (OUT_REG) begin : g_dly
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rd_p  <= '0;
                fix_p <= 1'b0;
                vld   <= 1'b0;
            end else begin
                rd_p  <= rd_data;
                fix_p <= fix_en;
                vld   <= 1'b1;
            end
        end
    end else begin : g_nodly
        assign rd_p  = rd_data;
        assign fix_p = fix_en;
        assign vld   = 1'b1;
    end

    assert_syn_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        syndrome[SW-1:CW] == '0);

    assert_clean_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (syndrome == '0) |-> (ce_n && nce_n));

    assert_ce_weight_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> ($countones(syndrome) == 1 || $countones(syndrome) == 3));

    assert_detect_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !fix_p) |-> (out_data == rd_p));

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ce_n && !nce_n));

    assert_even_nce_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (syndrome != '0 && $countones(syndrome) % 2 == 0) |-> !nce_n);

    assert_nce_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !nce_n) |-> (out_data == rd_p));

    assert_one_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> ($countones(out_data ^ rd_p) <= 1));

endmodule

bind edac16_secded edac16_secded_chk #(.OUT_REG(OUT_REG)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_data  (rd_data),
    .fix_en   (fix_en),
    .out_data (out_data),
    .syndrome (syndrome),
    .ce_n     (ce_n),
    .nce_n    (nce_n)
);

// File: tb/edac16_secded_tb_top.sv
`timescale 1ns/1ps
module edac16_secded_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] wr_data = '0;
    logic [5:0]  wr_check;
    logic [15:0] rd_data = '0;
    logic [5:0]  rd_check = '0;
    logic        fix_en = 1'b0;
    logic [15:0] out_data;
    logic [7:0]  syndrome;
    logic        ce_n;
    logic        nce_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    edac16_secded #(.OUT_REG(1'b1)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_data  (wr_data),
        .wr_check (wr_check),
        .rd_data  (rd_data),
        .rd_check (rd_check),
        .fix_en   (fix_en),
        .out_data (out_data),
        .syndrome (syndrome),
        .ce_n     (ce_n),
        .nce_n    (nce_n)
    );

    function automatic logic [5:0] bcol(input int i);
        case (i)
            0:  return 6'h0D;  1: return 6'h0E;  2: return 6'h1C;  3: return 6'h2C;
            4:  return 6'h0B;  5: return 6'h15;  6: return 6'h23;  7: return 6'h31;
            8:  return 6'h13;  9: return 6'h16; 10: return 6'h1A; 11: return 6'h32;
            12: return 6'h25; 13: return 6'h29; 14: return 6'h2A; 15: return 6'h34;
            default: return 6'h00;
        endcase
    endfunction

    function automatic logic [5:0] bgen(input logic [15:0] d);
        logic [5:0] c = '0;
        for (int i = 0; i < 16; i++) begin
            if (d[i]) c ^= bcol(i);
        end
        return c;
    endfunction

    // Flip position p of a stored word: 0..15 data, 16..21 check.
    task automatic flip(input int p, inout logic [15:0] d, inout logic [5:0] c);
        if (p < 16) d[p] = ~d[p];
        else        c[p-16] = ~c[p-16];
    endtask

    task automatic run_case(input string tag, input logic [15:0] rd, input logic [5:0] rc,
                            input logic fx);
        logic [15:0] wd;
        logic [5:0]  s;
        int          idx;
        logic        ece, ence;
        logic [15:0] edat;
        logic [5:0]  ewc;
        wd       = 16'($urandom);
        wr_data  = wd;
        rd_data  = rd;
        rd_check = rc;
        fix_en   = fx;
        @(negedge clk);
        s   = bgen(rd) ^ rc;
        idx = -1;
        for (int i = 0; i < 16; i++) begin
            if (bcol(i) == s) idx = i;
        end
        ece  = !(($countones(s) == 1) || (idx >= 0));
        ence = !((s != 0) && ece);
        edat = rd;
        if (fx && idx >= 0) edat[idx] = ~edat[idx];
        ewc  = bgen(wd);
        checks++;
        if (out_data !== edat || syndrome !== {2'b00, s} || ce_n !== ece ||
            nce_n !== ence || wr_check !== ewc) begin
            fails++;
            $display("FAIL %s: got data=%h syn=%h ce_n=%b nce_n=%b wchk=%h exp data=%h syn=%h ce_n=%b nce_n=%b wchk=%h",
                     tag, out_data, syndrome, ce_n, nce_n, wr_check,
                     edat, {2'b00, s}, ece, ence, ewc);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [5:0]  c;
        int          seed;
        seed = $urandom(32'h00C0FFEE);
        seed = 0;

        // R9: reset state
        repeat (3) @(negedge clk);
        rd_data = 16'hBEEF; rd_check = 6'h3F; fix_en = 1'b1;
        @(negedge clk);
        checks++;
        if (out_data !== 16'h0 || syndrome !== 8'h0 || ce_n !== 1'b1 || nce_n !== 1'b1) begin
            fails++;
            $display("FAIL R9: got data=%h syn=%h ce_n=%b nce_n=%b exp 0000 00 1 1",
                     out_data, syndrome, ce_n, nce_n);
        end
        rst_n = 1'b1;

        // R1, R3: clean words, one-hot write patterns
        for (int i = 0; i < 16; i++) begin
            d = 16'h1 << i;
            run_case("R1", d, bgen(d), 1'b1);
        end
        run_case("R3", 16'hFFFF, bgen(16'hFFFF), 1'b1);
        run_case("R3", 16'h0000, 6'h00, 1'b0);

        // R4, R6 (fix mode) and R5 (detect mode): every single flip
        for (int p = 0; p < 22; p++) begin
            d = 16'($urandom); c = bgen(d);
            flip(p, d, c);
            run_case(p < 16 ? "R4" : "R6", d, c, 1'b1);
            run_case("R5", d, c, 1'b0);
        end

        // R7: every double flip, plus the data4/check2 example (syndrome 0F)
        for (int a = 0; a < 22; a++) begin
            for (int b = a + 1; b < 22; b++) begin
                d = 16'($urandom); c = bgen(d);
                flip(a, d, c); flip(b, d, c);
                run_case("R7", d, c, 1'b1);
            end
        end
        d = 16'h0000; c = 6'h00; flip(4, d, c); flip(18, d, c);
        run_case("R7", d, c, 1'b1);

        // R7: 4-bit group failure on data bits 3..0 (syndrome 33)
        d = 16'hA5A5; c = bgen(d); d ^= 16'h000F;
        run_case("R7", d, c, 1'b1);

        // R8: odd-weight syndromes matching no column (07 and 1F)
        d = 16'h1234; c = bgen(d) ^ 6'h07;
        run_case("R8", d, c, 1'b1);
        d = 16'h4321; c = bgen(d) ^ 6'h1F;
        run_case("R8", d, c, 1'b1);

        // R10: triple alias onto data bit 12 (syndrome 25), fix and detect modes
        d = 16'h0000; c = 6'h00; flip(0, d, c); flip(14, d, c); flip(17, d, c);
        run_case("R10", d, c, 1'b1);
        checks++;
        if (out_data !== 16'h5001) begin
            fails++;
            $display("FAIL R10: got data=%h exp data=5001", out_data);
        end
        run_case("R10", d, c, 1'b0);

        // Random injections of 0..3 flips alongside random writes
        for (int n = 0; n < 400; n++) begin
            int k;
            int p0, p1, p2;
            d  = 16'($urandom); c = bgen(d);
            k  = int'($urandom % 4);
            p0 = int'($urandom % 22);
            p1 = int'((p0 + 1 + $urandom % 21) % 22);
            p2 = p0;
            while (p2 == p0 || p2 == p1) p2 = int'($urandom % 22);
            if (k >= 1) flip(p0, d, c);
            if (k >= 2) flip(p1, d, c);
            if (k >= 3) flip(p2, d, c);
            run_case(k == 0 ? "R3" : (k == 1 ? "R4" : (k == 2 ? "R7" : "R8")),
                     d, c, 1'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule